// File: doc/BRIEF.md
# PWM Counter-Compare with Shadowed Thresholds

This block watches a free-running PWM time-base count and raises a one-cycle match pulse whenever the count equals one of four thresholds (A, B, C, D). Pulses A and B are meant for an action-qualifier stage and travel with a registered copy of the counting direction. Pulses C and D are meant for an event-trigger stage. The time base, the qualifier and the trigger logic sit outside this block.

Every threshold is double-buffered. Software can write the live (active) copy directly, which changes the comparison on the next cycle. It can also write the staged (shadow) copy, which is copied into the live copy only at a chosen point of the count. That point is set per threshold: count at zero, count at period, either, or never. A global override can instead make all four copy together when a single external load pulse arrives. Only the live copies are compared, so a shadow value never produces a pulse on its own.

Because a pulse fires only when the count moves onto a new value, an up-count sweep yields one pulse per threshold per period. An up-down sweep yields two pulses for a threshold strictly inside the range. It yields one pulse for a threshold at zero or at the period, since the count turns around there.

Top module: `pwm_cmp_shadow`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are low after that edge, and every live value, staged value and the control word become zero.
- R2: A write (`wr_en`=1) to address 0, 1, 2 or 3 sets the live value of A, B, C or D. That value is compared from the next cycle on, whatever the load setting.
- R3: When `cnt` equals a live value at a rising edge and the count is new, the matching `ev_*` output is high for exactly the cycle after that edge.
- R4: If `cnt` holds the same value across consecutive edges, no further pulse is produced for it. The first sample after reset always counts as new.
- R5: A write to address 4, 5, 6 or 7 changes only the staged value of A, B, C or D, and has no effect on pulses until a load moves it to the live value.
- R6: Address 8 holds the control word: bits [1:0], [3:2], [5:4] and [7:6] give the load setting of A, B, C and D. Setting 0 loads when `cnt`==0, 1 when `cnt`==`prd`, 2 on either, and 3 never.
- R7: When control bit 8 is set, the per-threshold settings are ignored, and all four staged values load together on any cycle with `glb_load`=1.
- R8: If a staged write and a load for the same threshold fall in one cycle, the newly written value becomes live.
- R9: If a live write and a load for the same threshold fall in one cycle, the live write wins.
- R10: In up-count mode (`updown`=0) each threshold pulses once per period. In up-down mode it pulses twice per period if it lies strictly between 0 and `prd`, and once if it equals 0 or `prd`.
- R11: `ev_dir` is a registered copy of `dir_up` in up-down mode, and is 1 in up-count mode. It shares the one-cycle delay of the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | CW | Time-base count |
| prd | input | CW | Time-base period |
| updown | input | 1 | 0 = up-count, 1 = up-down count |
| dir_up | input | 1 | Current count direction, 1 = rising |
| glb_load | input | 1 | Global load pulse (used when control bit 8 is set) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address (0-3 live A-D, 4-7 staged A-D, 8 control) |
| wr_data | input | CW | Write data |
| ev_a | output | 1 | Threshold A match pulse |
| ev_b | output | 1 | Threshold B match pulse |
| ev_c | output | 1 | Threshold C match pulse |
| ev_d | output | 1 | Threshold D match pulse |
| ev_dir | output | 1 | Direction qualifier for the A and B pulses |

## Verification
The hardest cases to reach from the ports are the collisions: a staged or live write landing on the exact cycle the count sits at zero. No status is readable, so the result shows only through where later pulses fall. The stimulus therefore times writes to coincide with `cnt`=0 and then sweeps a full period, so that a wrong resolution moves a pulse to another count value. A behavioural model checks every output on every cycle, and pulse totals over whole up-down periods confirm the once-or-twice rule at 0, at `prd` and in between.

// File: rtl/pwm_cmp_pkg.sv
`timescale 1ns/1ps
package pwm_cmp_pkg;
  // Per-threshold load point selection
  typedef enum logic [1:0] {
    LD_ZERO = 2'd0,
    LD_PRD  = 2'd1,
    LD_BOTH = 2'd2,
    LD_OFF  = 2'd3
  } ld_mode_e;

  localparam int NCH       = 4;           // thresholds A..D
  localparam int ACT_BASE  = 0;           // live copies
  localparam int SHD_BASE  = ACT_BASE + NCH;
  localparam int CTRL_ADDR = SHD_BASE + NCH;
  localparam int GLB_BIT   = 2 * NCH;     // global-load enable bit
  localparam int CTRL_W    = GLB_BIT + 1;
endpackage

// File: rtl/pwm_cmp_tbmon.sv
`timescale 1ns/1ps
// Watches the time-base count: flags a new count value and the load points.
module pwm_cmp_tbmon #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] prd,
  output logic          fresh,
  output logic          at_zero,
  output logic          at_prd
);
  logic [CW-1:0] cnt_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt;
      seen_q <= 1'b1;
    end
  end

  assign fresh   = !seen_q || (cnt != cnt_q);
  assign at_zero = (cnt == '0);
  assign at_prd  = (cnt == prd);

  // R4: once a value has been sampled, holding it is never new
  p_hold_not_fresh_r4: assert property (@(posedge clk) disable iff (rst)
    seen_q && $stable(cnt) |-> !fresh);
endmodule

// File: rtl/pwm_cmp_ldsel.sv
`timescale 1ns/1ps
// Chooses the load strobe of one threshold: per-threshold point or global pulse.
module pwm_cmp_ldsel
  import pwm_cmp_pkg::*;
(
  input  ld_mode_e mode,
  input  logic     glb_en,
  input  logic     glb_load,
  input  logic     at_zero,
  input  logic     at_prd,
  output logic     ld_stb
);
  logic local_stb;

  always_comb begin
    unique case (mode)
      LD_ZERO: local_stb = at_zero;
      LD_PRD:  local_stb = at_prd;
      LD_BOTH: local_stb = at_zero | at_prd;
      default: local_stb = 1'b0;
    endcase
    ld_stb = glb_en ? glb_load : local_stb;
  end
endmodule

// File: rtl/pwm_cmp_chan.sv
`timescale 1ns/1ps
// One threshold: staged and live copies, and a registered match pulse.
module pwm_cmp_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_we,
  input  logic          shd_we,
  input  logic [CW-1:0] wdata,
  input  logic          ld_stb,
  input  logic          fresh,
  input  logic [CW-1:0] cnt,
  output logic          ev
);
  logic [CW-1:0] shd_q;
  logic [CW-1:0] act_q;
  logic [CW-1:0] shd_next;

  // a staged write in the load cycle is forwarded straight to the live copy
  assign shd_next = shd_we ? wdata : shd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q <= '0;
      act_q <= '0;
      ev    <= 1'b0;
    end else begin
      shd_q <= shd_next;
      if (act_we)
        act_q <= wdata;
      else if (ld_stb)
        act_q <= shd_next;
      ev <= fresh && (cnt == act_q);
    end
  end

  // R2 R9: a live write always lands, even against a load
  p_live_write_r2: assert property (@(posedge clk) disable iff (rst)
    act_we |=> act_q == $past(wdata));
  // R8: staged write coinciding with a load becomes live
  p_fwd_stage_r8: assert property (@(posedge clk) disable iff (rst)
    ld_stb && shd_we && !act_we |=> act_q == $past(wdata));
  // R5: without a load or live write the live copy does not move
  p_live_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !act_we && !ld_stb |=> $stable(act_q));
  // R3: a pulse follows a match of the previous cycle
  p_pulse_match_r3: assert property (@(posedge clk) disable iff (rst)
    ev |-> $past(cnt) == $past(act_q));
endmodule

// File: rtl/pwm_cmp_shadow.sv
`timescale 1ns/1ps
module pwm_cmp_shadow
  import pwm_cmp_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] prd,
  input  logic          updown,
  input  logic          dir_up,
  input  logic          glb_load,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          ev_a,
  output logic          ev_b,
  output logic          ev_c,
  output logic          ev_d,
  output logic          ev_dir
);
  localparam logic [AW-1:0] CTRL_SEL = AW'(CTRL_ADDR);

  logic [CTRL_W-1:0] ctrl_q;
  logic [NCH-1:0]    act_we, shd_we, ld_stb, ev_v;
  logic              fresh, at_zero, at_prd;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ev_dir <= 1'b0;
    end else begin
      if (wr_en && wr_addr == CTRL_SEL)
        ctrl_q <= wr_data[CTRL_W-1:0];
      ev_dir <= updown ? dir_up : 1'b1;
    end
  end

  pwm_cmp_tbmon #(.CW(CW)) tbmon_i (
    .clk(clk), .rst(rst), .cnt(cnt), .prd(prd),
    .fresh(fresh), .at_zero(at_zero), .at_prd(at_prd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign act_we[i] = wr_en && (wr_addr == AW'(ACT_BASE + i));
    assign shd_we[i] = wr_en && (wr_addr == AW'(SHD_BASE + i));

    pwm_cmp_ldsel ldsel_i (
      .mode(ld_mode_e'(ctrl_q[2*i +: 2])),
      .glb_en(ctrl_q[GLB_BIT]),
      .glb_load(glb_load),
      .at_zero(at_zero),
      .at_prd(at_prd),
      .ld_stb(ld_stb[i])
    );

    pwm_cmp_chan #(.CW(CW)) chan_i (
      .clk(clk), .rst(rst),
      .act_we(act_we[i]), .shd_we(shd_we[i]), .wdata(wr_data),
      .ld_stb(ld_stb[i]), .fresh(fresh), .cnt(cnt),
      .ev(ev_v[i])
    );
  end

  assign {ev_d, ev_c, ev_b, ev_a} = ev_v;

  // R4: a held count yields no pulse on any threshold
  p_no_repeat_r4: assert property (@(posedge clk) disable iff (rst)
    !fresh |=> ev_v == '0);
  // R11: up-count mode always reports rising
  p_dir_up_mode_r11: assert property (@(posedge clk) disable iff (rst)
    !updown |=> ev_dir);
  // R7: global mode without the pulse never loads any threshold
  p_glb_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[GLB_BIT] && !glb_load |-> ld_stb == '0);
endmodule

// File: tb/pwm_cmp_shadow_tb.sv
`timescale 1ns/1ps
module pwm_cmp_shadow_tb_top;
  localparam int CW = 16;
  localparam int AW = 4;
  localparam int PRD = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cnt = 16'd9;
  logic [CW-1:0] prd = 16'(PRD);
  logic updown = 1'b0, dir_up = 1'b0, glb_load = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic ev_a, ev_b, ev_c, ev_d, ev_dir;

  always #5 clk = ~clk;

  pwm_cmp_shadow #(.CW(CW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .cnt(cnt), .prd(prd), .updown(updown),
    .dir_up(dir_up), .glb_load(glb_load), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ev_a(ev_a), .ev_b(ev_b), .ev_c(ev_c), .ev_d(ev_d),
    .ev_dir(ev_dir)
  );

  int nchk = 0, nerr = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int  m_act[4], m_shd[4], m_ctrl, m_prev;
  bit  m_seen;
  bit  e_ev[4];
  bit  e_dir;

  always @(posedge clk) begin
    bit nw, ld;
    int md;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_shd[i] = 0; e_ev[i] = 0; end
      m_ctrl = 0; m_seen = 0; m_prev = 0; e_dir = 0;
    end else begin
      nw = !m_seen || (int'(cnt) != m_prev);
      for (int i = 0; i < 4; i++) e_ev[i] = nw && (int'(cnt) == m_act[i]);
      e_dir = updown ? dir_up : 1'b1;
      for (int i = 0; i < 4; i++) begin
        md = (m_ctrl >> (2*i)) & 3;
        if (m_ctrl[8]) ld = glb_load;
        else ld = (md == 0 && cnt == 0) || (md == 1 && cnt == prd) ||
                  (md == 2 && (cnt == 0 || cnt == prd));
        if (wr_en && int'(wr_addr) == i) m_act[i] = int'(wr_data);
        else if (ld) m_act[i] = (wr_en && int'(wr_addr) == i + 4) ? int'(wr_data) : m_shd[i];
        if (wr_en && int'(wr_addr) == i + 4) m_shd[i] = int'(wr_data);
      end
      if (wr_en && int'(wr_addr) == 8) m_ctrl = int'(wr_data) & 'h1FF;
      m_prev = int'(cnt); m_seen = 1;
    end
  end

  int pc[4];
  always @(negedge clk) begin
    logic [3:0] got;
    got = {ev_d, ev_c, ev_b, ev_a};
    for (int i = 0; i < 4; i++) begin
      chk(got[i] === e_ev[i], tag, int'(got[i]), int'(e_ev[i]));
      if (got[i] === 1'b1) pc[i]++;
    end
    chk(ev_dir === e_dir, (tag == "R10") ? "R11" : tag, int'(ev_dir), int'(e_dir));
  end

  // one cycle of stimulus, applied after a falling edge
  task automatic cyc(input int c, input bit we = 0, input int a = 0,
                     input int d = 0, input bit gl = 0);
    @(negedge clk);
    cnt = 16'(c); wr_en = we; wr_addr = 4'(a); wr_data = 16'(d); glb_load = gl;
  endtask

  task automatic sweep_up();
    for (int v = 0; v <= PRD; v++) cyc(v);
  endtask

  int base[4];
  task automatic snap();
    @(negedge clk);
    for (int i = 0; i < 4; i++) base[i] = pc[i];
  endtask
  task automatic expect_pulses(input string req, input int ea, input int eb,
                               input int ec, input int ed);
    int e[4];
    e = '{ea, eb, ec, ed};
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 4; i++) chk(pc[i] - base[i] == e[i], req, pc[i] - base[i], e[i]);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) pc[i] = 0;
    repeat (3) @(negedge clk);
    // R1: outputs low while in reset
    chk({ev_a, ev_b, ev_c, ev_d, ev_dir} === 5'b0, "R1", int'({ev_a, ev_b, ev_c, ev_d, ev_dir}), 0);
    cyc(9); rst = 1'b0;
    cyc(9);
    tag = "R2";
    cyc(9, 1, 8, 'hFF);         // all thresholds: never load
    cyc(9, 1, 0, 5); cyc(9, 1, 1, 10); cyc(9, 1, 2, 3); cyc(9, 1, 3, 7);
    cyc(9);
    // R3 R10: up-count, two periods, one pulse each per period
    tag = "R3"; snap();
    sweep_up(); sweep_up();
    expect_pulses("R10", 2, 2, 2, 2);
    // R4: stalled count at A's value
    tag = "R4"; cyc(9); snap();
    repeat (5) cyc(5);
    expect_pulses("R4", 1, 0, 0, 0);
    // R5 R6: A never, B at period, C at zero, D at either
    tag = "R5 R6";
    cyc(9, 1, 8, 3 | (1 << 2) | (0 << 4) | (2 << 6));
    cyc(9, 1, 4, 6); cyc(9, 1, 5, 11); cyc(9, 1, 6, 4); cyc(9, 1, 7, 8);
    sweep_up(); sweep_up();
    // R7: global mode, no load at zero until the pulse
    tag = "R7";
    cyc(9, 1, 8, 'h100);
    cyc(9, 1, 4, 12); cyc(9, 1, 5, 13); cyc(9, 1, 6, 14); cyc(9, 1, 7, 2);
    snap(); sweep_up();
    expect_pulses("R7", 1, 1, 1, 1);  // old values 5,11,4,8 still live
    cyc(9, 0, 0, 0, 1);
    cyc(9); sweep_up();
    // R8: staged write exactly at the zero load point
    tag = "R8";
    cyc(9, 1, 8, 0);
    cyc(9); cyc(0, 1, 4, 3);
    for (int v = 1; v <= PRD; v++) cyc(v);
    // R9: live write beats the zero load of B (staged 13)
    tag = "R9";
    cyc(9); cyc(0, 1, 1, 6);
    for (int v = 1; v <= PRD; v++) cyc(v);
    // R10 R11: up-down, thresholds inside, at period, at zero, out of range
    tag = "R10";
    cyc(9, 1, 8, 'hFF);
    cyc(9, 1, 0, 5); cyc(9, 1, 1, PRD); cyc(9, 1, 2, 0); cyc(9, 1, 3, 20);
    @(negedge clk); updown = 1'b1;
    snap();
    for (int k = 0; k < 4 * PRD; k++) begin
      int v;
      v = k % (2 * PRD);
      @(negedge clk);
      wr_en = 1'b0; glb_load = 1'b0;
      cnt = 16'((v <= PRD) ? v : 2 * PRD - v);
      dir_up = (v < PRD);
    end
    expect_pulses("R10", 4, 2, 2, 0);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #2000000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule